// File: doc/BRIEF.md
# PCI Error Reporting and Sticky Status Logic

This block gathers error events from the PCI side of a bridge. It decides for each event whether the system error output (SERR#) or the parity error output (PERR#) is pulsed. Every event first passes a per-event enable in a command register. A global enable taken from the device command register then gates it a second time. The block also keeps a status register of sticky flags. Software clears these flags by writing ones to them. One of the flags records a host bus shutdown cycle, and that flag can also raise a request to assert INIT.

The register port is a flat select/write/read interface. `cfg_sel` picks the command register (0) or the status register (1). A write takes effect on the clock edge on which `cfg_wr` is high. Reads are combinational from the selected register. Event inputs are single-cycle pulses sampled on the rising clock edge.

Top module: `pci_err_report`

## Requirements
- R1: After reset, both registers read 0x00, `serr_n` and `perr_n` are high, and `init_req` is low.
- R2: In the command register, bits 7:3 are writable and read back as written. Bits 2:0 ignore writes and always read 0.
- R3: A SERR cause exists when `glb_serr_en` is 1 and at least one of these holds: target abort with command bit 7, PERR seen while writing with bit 6, bad read data parity with bit 5, bad address parity with bit 4. When a clock edge samples a SERR cause, `serr_n` is low for exactly the following cycle.
- R4: When `glb_serr_en` is 0, `serr_n` stays high whatever the contents of command bits 7:4.
- R5: `perr_n` goes low for one cycle after an edge that samples all three of the following: bad read data parity, command bit 3, and `glb_par_chk_en`. No other event drives `perr_n`.
- R6: Events set status flags whether or not any enable is set. PERR seen while writing sets bit 6. Bad read parity sets bit 5. Bad address parity sets bit 4. A host shutdown sets bit 0. A target abort sets no status flag.
- R7: A status write of 1 to a flag clears that flag. A status write of 0 to a flag leaves it unchanged.
- R8: If an event and a clearing write reach the same status flag on the same edge, the flag ends up set.
- R9: Status bits 7 and 3:1 always read 0.
- R10: `init_req` is high for one cycle after an edge that samples a host shutdown while `shutdown_init_en` is 1. It stays low otherwise.
- R11: Reported events on consecutive edges give consecutive low cycles on the matching output, one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_tgt_abort | input | 1 | Target abort received as master |
| ev_perr_wr | input | 1 | PERR# observed while writing data |
| ev_rd_par | input | 1 | Bad parity on received read data |
| ev_addr_par | input | 1 | Bad address parity from another master |
| ev_shutdown | input | 1 | Host bus shutdown cycle detected |
| glb_serr_en | input | 1 | Global SERR enable from command register |
| glb_par_chk_en | input | 1 | Global parity checking enable |
| shutdown_init_en | input | 1 | Request INIT on shutdown |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = command register, 1 = status register |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of selected register |
| serr_n | output | 1 | Active-low system error pulse |
| perr_n | output | 1 | Active-low parity error pulse |
| init_req | output | 1 | INIT request pulse |

## Verification
An event sampled on edge N shows up on `serr_n`, `perr_n` and `init_req` in the cycle after edge N. The status flag for that event can be read combinationally in the same cycle. A command write on edge N already gates events sampled on edge N+1. The bench drives its inputs on falling edges and samples each result on the falling edge right after the rising edge that produces it. It samples once more a cycle later to confirm that each pulse lasts a single cycle.

// File: rtl/pci_err_pkg.sv
package pci_err_pkg;
  localparam int REG_W   = 8;
  localparam int N_STICK = 4;

  // command register bit positions
  localparam int CMD_TA = 7;
  localparam int CMD_PW = 6;
  localparam int CMD_RP = 5;
  localparam int CMD_AP = 4;
  localparam int CMD_PE = 3;
  localparam logic [REG_W-1:0] CMD_MASK = 8'hF8;

  // status flag positions, index k of the sticky array
  localparam int ST_POS [N_STICK] = '{6, 5, 4, 0};

  typedef struct packed {
    logic tgt_abort;
    logic perr_wr;
    logic rd_par;
    logic addr_par;
    logic shutdown;
  } err_ev_t;

  function automatic logic serr_cause(logic [REG_W-1:0] cmd, logic glb, err_ev_t ev);
    logic any;
    any = (ev.tgt_abort & cmd[CMD_TA]) | (ev.perr_wr & cmd[CMD_PW]) |
          (ev.rd_par & cmd[CMD_RP]) | (ev.addr_par & cmd[CMD_AP]);
    return glb & any;
  endfunction

  function automatic logic perr_cause(logic [REG_W-1:0] cmd, logic glb, err_ev_t ev);
    return glb & cmd[CMD_PE] & ev.rd_par;
  endfunction

  function automatic logic [N_STICK-1:0] stick_src(err_ev_t ev);
    return {ev.shutdown, ev.addr_par, ev.rd_par, ev.perr_wr};
  endfunction
endpackage

// File: rtl/err_cmd_reg.sv
module err_cmd_reg
  import pci_err_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] cmd_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cmd_q <= '0;
    else if (wr_en) cmd_q <= wdata & CMD_MASK;
  end
endmodule

// File: rtl/err_sticky_bit.sv
module err_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  // set has priority over a same-edge clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= set_i | (q & ~clr_i);
  end
endmodule

// File: rtl/err_pulse_gen.sv
module err_pulse_gen #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] pulse_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= '0;
    else        pulse_q <= req;
  end
endmodule

// File: rtl/pci_err_report.sv
module pci_err_report
  import pci_err_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_tgt_abort,
  input  logic             ev_perr_wr,
  input  logic             ev_rd_par,
  input  logic             ev_addr_par,
  input  logic             ev_shutdown,
  input  logic             glb_serr_en,
  input  logic             glb_par_chk_en,
  input  logic             shutdown_init_en,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             serr_n,
  output logic             perr_n,
  output logic             init_req
);
  localparam int N_OUT = 3;

  err_ev_t          ev;
  logic [REG_W-1:0] cmd_q;
  logic [REG_W-1:0] stat_q;
  logic             cmd_wr, stat_wr;
  logic             serr_hit, perr_hit, init_hit;
  logic [N_STICK-1:0] set_vec, clr_vec, bit_q;
  logic [N_OUT-1:0]   pulse_q;

  assign ev      = '{tgt_abort: ev_tgt_abort, perr_wr: ev_perr_wr, rd_par: ev_rd_par,
                     addr_par: ev_addr_par, shutdown: ev_shutdown};
  assign cmd_wr  = cfg_wr & ~cfg_sel;
  assign stat_wr = cfg_wr & cfg_sel;

  err_cmd_reg i_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(cmd_wr), .wdata(cfg_wdata), .cmd_q(cmd_q)
  );

  // named cause wires
  assign serr_hit = serr_cause(cmd_q, glb_serr_en, ev);
  assign perr_hit = perr_cause(cmd_q, glb_par_chk_en, ev);
  assign init_hit = ev_shutdown & shutdown_init_en;

  assign set_vec = stick_src(ev);

  for (genvar k = 0; k < N_STICK; k++) begin : g_stick
    assign clr_vec[k] = stat_wr & cfg_wdata[ST_POS[k]];
    err_sticky_bit i_bit (
      .clk(clk), .rst_n(rst_n), .set_i(set_vec[k]), .clr_i(clr_vec[k]), .q(bit_q[k])
    );
  end

  always_comb begin
    stat_q = '0;
    for (int k = 0; k < N_STICK; k++) stat_q[ST_POS[k]] = bit_q[k];
  end

  err_pulse_gen #(.N(N_OUT)) i_pulse (
    .clk(clk), .rst_n(rst_n), .req({init_hit, perr_hit, serr_hit}), .pulse_q(pulse_q)
  );

  assign serr_n    = ~pulse_q[0];
  assign perr_n    = ~pulse_q[1];
  assign init_req  = pulse_q[2];
  assign cfg_rdata = cfg_sel ? stat_q : cmd_q;
endmodule

// File: rtl/pci_err_report_chk.sv
module pci_err_report_chk
  import pci_err_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ev_perr_wr,
  input logic             ev_rd_par,
  input logic             ev_addr_par,
  input logic             ev_shutdown,
  input logic             glb_serr_en,
  input logic             glb_par_chk_en,
  input logic             shutdown_init_en,
  input logic             cfg_wr,
  input logic             cfg_sel,
  input logic [REG_W-1:0] cfg_wdata,
  input logic [REG_W-1:0] cfg_rdata,
  input logic [REG_W-1:0] stat_q,
  input logic             serr_hit,
  input logic             serr_n,
  input logic             perr_n,
  input logic             init_req
);
  a_r3_serr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    serr_hit |=> !serr_n);
  a_r3_serr_global: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n |-> $past(glb_serr_en));
  a_r4_serr_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_serr_en |=> serr_n);
  a_r5_perr_src: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> $past(ev_rd_par && glb_par_chk_en));
  a_r6_addr_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_par |=> stat_q[4]);
  a_r6_sd_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_shutdown |=> stat_q[0]);
  a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel && cfg_wdata[5] && !ev_rd_par) |=> !stat_q[5]);
  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel && cfg_wdata[6] && ev_perr_wr) |=> stat_q[6]);
  a_r9_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sel |-> ((cfg_rdata & 8'h8E) == 8'h00));
  a_r10_init_src: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |-> $past(ev_shutdown && shutdown_init_en));
endmodule

bind pci_err_report pci_err_report_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ev_perr_wr(ev_perr_wr), .ev_rd_par(ev_rd_par),
  .ev_addr_par(ev_addr_par), .ev_shutdown(ev_shutdown), .glb_serr_en(glb_serr_en),
  .glb_par_chk_en(glb_par_chk_en), .shutdown_init_en(shutdown_init_en),
  .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
  .stat_q(stat_q), .serr_hit(serr_hit), .serr_n(serr_n), .perr_n(perr_n),
  .init_req(init_req)
);

// File: tb/test_pci_err_report.sv
`timescale 1ns/1ps
module test_pci_err_report;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ta = 0, pw = 0, rp = 0, ap = 0, sd = 0;
  logic gs = 0, gp = 0, ie = 0;
  logic wr = 0, sel = 0;
  logic [7:0] wd = 0;
  logic [7:0] rd;
  logic serr_n, perr_n, init_req;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  pci_err_report i_pci_err_report (
    .clk(clk), .rst_n(rst_n), .ev_tgt_abort(ta), .ev_perr_wr(pw), .ev_rd_par(rp),
    .ev_addr_par(ap), .ev_shutdown(sd), .glb_serr_en(gs), .glb_par_chk_en(gp),
    .shutdown_init_en(ie), .cfg_wr(wr), .cfg_sel(sel), .cfg_wdata(wd),
    .cfg_rdata(rd), .serr_n(serr_n), .perr_n(perr_n), .init_req(init_req)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic nx();
    @(negedge clk);
  endtask

  task automatic set_ev(input logic [4:0] e);
    {ta, pw, rp, ap, sd} = e;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    nx(); nx();
    rst_n = 1'b1;
    nx();
    // R1 reset state
    chk("R1 serr_n", {7'd0, serr_n}, 8'd1);
    chk("R1 perr_n", {7'd0, perr_n}, 8'd1);
    chk("R1 init_req", {7'd0, init_req}, 8'd0);
    sel = 0; #1 chk("R1 cmd", rd, 8'h00);
    sel = 1; #1 chk("R1 status", rd, 8'h00);

    // R2 command write ignores reserved bits
    nx(); sel = 0; wr = 1; wd = 8'hFF;
    nx(); wr = 0; chk("R2 cmd all ones", rd, 8'hF8);

    for (int nib = 0; nib < 16; nib++) begin
      for (int mode = 0; mode < 16; mode++) begin
        for (int e = 0; e < 32; e++) begin
          logic c3, es, ep, ei;
          logic [7:0] est;
          logic [4:0] ev;
          ev = e[4:0];
          c3 = mode[2];
          gs = mode[0]; gp = mode[1]; ie = mode[3];
          sel = 0; wr = 1; wd = {nib[3:0], c3, 3'b111};
          nx();
          wr = 0;
          chk("R2 cmd readback", rd, {nib[3:0], c3, 3'b000});
          sel = 1; set_ev(ev);
          // expected values from requirements
          es = gs & ((ev[4] & nib[3]) | (ev[3] & nib[2]) | (ev[2] & nib[1]) | (ev[1] & nib[0]));
          ep = gp & c3 & ev[2];
          ei = ie & ev[0];
          est = {1'b0, ev[3], ev[2], ev[1], 3'b000, ev[0]};
          nx();
          set_ev(5'b0);
          chk(gs ? "R3 serr_n" : "R4 serr_n gated", {7'd0, serr_n}, {7'd0, ~es});
          chk("R5 perr_n", {7'd0, perr_n}, {7'd0, ~ep});
          chk("R10 init_req", {7'd0, init_req}, {7'd0, ei});
          chk("R6 R9 status flags", rd, est);
          nx();
          chk("R3 serr one cycle", {7'd0, serr_n}, 8'd1);
          chk("R5 perr one cycle", {7'd0, perr_n}, 8'd1);
          chk("R10 init one cycle", {7'd0, init_req}, 8'd0);
          wr = 1; wd = 8'hFF;
          nx();
          wr = 0;
          chk("R7 clear all", rd, 8'h00);
        end
      end
    end

    // R7 write of zero keeps flags, partial clear
    gs = 1; gp = 1; ie = 1;
    sel = 1; set_ev(5'b01111);
    nx(); set_ev(0); wr = 1; wd = 8'h00;
    nx(); wr = 0; chk("R7 write zero keeps", rd, 8'h71);
    wr = 1; wd = 8'h20;
    nx(); wr = 0; chk("R7 partial clear", rd, 8'h51);
    // R8 event and clear on same edge
    wr = 1; wd = 8'hFF; set_ev(5'b01000);
    nx(); wr = 0; set_ev(0); chk("R8 event wins", rd, 8'h40);
    wr = 1; wd = 8'hFF;
    nx(); wr = 0;

    // R11 back-to-back reported events
    sel = 0; wr = 1; wd = 8'hF8;
    nx(); wr = 0; set_ev(5'b10000);
    nx(); set_ev(5'b00010);
    chk("R11 first serr", {7'd0, serr_n}, 8'd0);
    nx(); set_ev(0);
    chk("R11 second serr", {7'd0, serr_n}, 8'd0);
    nx();
    chk("R11 serr released", {7'd0, serr_n}, 8'd1);
    set_ev(5'b00100);
    nx(); set_ev(5'b00100);
    chk("R11 first perr", {7'd0, perr_n}, 8'd0);
    nx(); set_ev(0);
    chk("R11 second perr", {7'd0, perr_n}, 8'd0);
    nx();
    chk("R11 perr released", {7'd0, perr_n}, 8'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule